// File: doc/BRIEF.md
# Floating-Point Exponential Unit

This block computes e^x for a compact binary floating-point format with a parameterized exponent field of `WE` bits and fraction field of `WF` bits. It uses an implicit leading one, the bias 2^(WE-1)-1 and no subnormals. The input is converted to a signed fixed-point value with `WF+G` fraction bits. An integer power of two `E` is found by a constant multiplication by log2(e). The remainder `Y = x - E*ln2` is then formed exactly enough to keep it in a bounded range.

The top `K` bits of `Y` select an entry of a table of e^A, and that table is computed during elaboration. The remaining low part `Z` is corrected by `1 + Z + Z^2/2`, where the square uses only a truncated copy of `Z`, since the term is small. One product of the table entry and the correction gives the significand, which is normalized and rounded once to `WF` bits.

A result above the largest finite value saturates to infinity and raises `ovf`. A result below the smallest normal value flushes to zero and raises `unf`. The result appears one clock after `in_valid`.

Top module: `fp_exp`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `result`, `ovf` and `unf` are all zero until a valid input has been accepted.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and `result` then belongs to the input presented in that earlier cycle.
- R3: For every finite input whose exact e^x lies inside the normal range, `result` differs from e^x by at most one unit in the last place of e^x, and both flags are low.
- R4: An input whose exponent field is zero (either sign, any fraction) gives exactly 1.0: exponent field equal to the bias, fraction zero.
- R5: When e^x exceeds the largest finite value, `result` is +infinity (exponent field all ones, fraction zero) and `ovf` is 1.
- R6: When e^x is below the smallest normal value 2^(1-bias), `result` is all zeros and `unf` is 1.
- R7: Input +infinity gives +infinity, input -infinity gives +0, and a NaN input (exponent all ones, nonzero fraction) gives a NaN with the fraction MSB set; none of these raises a flag.
- R8: The sign bit of `result` (bit WE+WF) is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `x_in` in this cycle |
| x_in | input | WE+WF+1 | Operand: sign at MSB, then exponent field, then fraction |
| out_valid | output | 1 | `result` holds the value for the input of the previous cycle |
| result | output | WE+WF+1 | e^x in the same format |
| ovf | output | 1 | Result saturated to infinity |
| unf | output | 1 | Result flushed to zero |

## Verification
The hardest situations to reach from the ports are inputs whose exponential lands within an ulp of the overflow or underflow limit. The reduced argument sits right at a multiple of ln2 there, so the quotient estimate needs its one-step correction and the rounding may carry the significand to 2.0. Random operands spread over roughly 2^-14 to 2^5 in magnitude often meet the correction and the rounding carry, but they rarely land close to either threshold. The stimulus therefore also encodes values computed from ln(largest finite) and ln(smallest normal), together with their neighbours. At these points the bench accepts either side of the limit only inside a one-ulp band around it.

// File: rtl/fp_exp.sv
`timescale 1ns/1ps
module fp_exp #(
  parameter int WE = 6,
  parameter int WF = 10,
  parameter int G  = 4,
  parameter int K  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WE+WF:0]   x_in,
  output logic             out_valid,
  output logic [WE+WF:0]   result,
  output logic             ovf,
  output logic             unf
);
  localparam int BIAS  = 2**(WE-1) - 1;
  localparam int F     = WF + G;
  localparam int CF    = F + WE;
  localparam int WM    = WE - 1 + F;
  localparam int WX    = WM + 1;
  localparam int WL    = WX + WE;
  localparam int WY    = WL + 2;
  localparam int WEE   = WE + 3;
  localparam int WQ    = WX + CF + 2;
  localparam int W2    = F + 2 - 2*K;
  localparam int SQSH  = F + 5 - 2*K;
  localparam int ENT_W = F + 2;
  localparam int WP    = 2*F + 3;

  localparam logic [63:0] LN2_64 = 64'hB17217F7D1CF79AB;
  localparam logic [63:0] L2E_64 = 64'hB8AA3B295C17F0BB;
  localparam logic [CF-1:0] LN2C = LN2_64[63 -: CF];
  localparam logic [CF:0]   L2EC = L2E_64[63 -: CF+1];

  localparam logic [WE-1:0]  BIG_EXP = WE'(BIAS + WE - 1);
  localparam logic [WE:0]    SA0     = (WE+1)'(WE - 2 + BIAS);
  localparam logic signed [WEE-1:0] EMX   = WEE'(2**WE - 1);
  localparam logic signed [WEE-1:0] ONE_E = WEE'(1);
  localparam logic [WE+WF:0] INF_PAT = {1'b0, {WE{1'b1}}, {WF{1'b0}}};
  localparam logic [WE+WF:0] NAN_PAT = {1'b0, {WE{1'b1}}, 1'b1, {(WF-1){1'b0}}};

  function automatic logic [ENT_W-1:0] exp_entry(int a);
    longint unsigned yv, term, sum;
    yv   = longint'(a) << (30 - K);
    term = 64'd1 << 30;
    sum  = term;
    for (int n = 1; n < 20; n++) begin
      term = ((term * yv) >> 30) / longint'(n);
      sum  = sum + term;
    end
    return ENT_W'((sum + (64'd1 << (29 - F))) >> (30 - F));
  endfunction

  logic [ENT_W-1:0] tbl [2**K];
  for (genvar i = 0; i < 2**K; i++) begin : g_tbl
    assign tbl[i] = exp_entry(i);
  end

  logic          sx;
  logic [WE-1:0] ex;
  logic [WF-1:0] fx;
  assign {sx, ex, fx} = x_in;

  logic special, is_nan, big;
  assign special = &ex;
  assign is_nan  = special && (|fx);
  assign big     = !special && (ex >= BIG_EXP);

  logic [WM-1:0] full, mag;
  logic [WE:0]   sa;
  assign full = {(ex != '0), fx, {(WE-2+G){1'b0}}};
  assign sa   = SA0 - {1'b0, ex};
  assign mag  = full >> sa;

  logic signed [WX-1:0]  xs;
  logic signed [WL-1:0]  xl;
  logic signed [WQ-1:0]  prod;
  logic signed [WEE-1:0] e0, ec;
  assign xs   = sx ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign xl   = {xs, {WE{1'b0}}};
  assign prod = WQ'(xs) * WQ'($signed({1'b0, L2EC}));
  assign e0   = WEE'(prod >>> (F + CF));

  logic signed [WY-1:0] ln2s, y2, yc;
  logic yneg, yhi;
  assign ln2s = WY'($signed({1'b0, LN2C}));
  assign y2   = WY'(xl) - WY'(e0) * ln2s;
  assign yneg = y2[WY-1];
  assign yhi  = !yneg && (y2 >= ln2s);
  assign yc   = yneg ? y2 + ln2s : (yhi ? y2 - ln2s : y2);
  assign ec   = yneg ? e0 - ONE_E : (yhi ? e0 + ONE_E : e0);

  logic [F-1:0]    yf;
  logic [K-1:0]    a;
  logic [F-K-1:0]  z;
  logic [W2-1:0]   zt;
  logic [2*W2-1:0] sq;
  logic [F:0]      corr;
  logic [WP-1:0]   pm;
  logic [WF+2:0]   m;
  logic            norm;
  logic [WF-1:0]   fr;
  logic signed [WEE-1:0] er;
  assign yf   = yc[CF-1:WE];
  assign a    = yf[F-1 -: K];
  assign z    = yf[F-K-1:0];
  assign zt   = z[F-K-1 -: W2];
  assign sq   = zt * zt;
  assign corr = {1'b1, {F{1'b0}}} + (F+1)'(z) + (F+1)'(sq >> SQSH);
  assign pm   = WP'(tbl[a]) * WP'(corr);
  assign m    = pm[WP-1:F+G] + (WF+3)'(pm[F+G-1]);
  assign norm = m[WF+1];
  assign fr   = norm ? m[WF:1] : m[WF-1:0];
  assign er   = ec + (norm ? WEE'(BIAS + 1) : WEE'(BIAS));

  logic [WE+WF:0] res_c;
  logic ovf_c, unf_c;
  always_comb begin
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (is_nan)                          res_c = NAN_PAT;
    else if (special)                    res_c = sx ? '0 : INF_PAT;
    else if (big || (!er[WEE-1] && er >= EMX)) begin
      if (big && sx) begin res_c = '0; unf_c = 1'b1; end
      else           begin res_c = INF_PAT; ovf_c = 1'b1; end
    end
    else if (er[WEE-1] || er == '0) begin res_c = '0; unf_c = 1'b1; end
    else                                 res_c = {1'b0, er[WE-1:0], fr};
  end

  logic unused_ok;
  assign unused_ok = ^{yc[WE-1:0], z, pm, m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        ovf    <= ovf_c;
        unf    <= unf_c;
      end
    end
  end

  AST_REDUCED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !special && !big) |-> (yc[WY-1:CF] == '0)); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result == INF_PAT && !unf)); // R5
  AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result == '0 && !ovf)); // R6
  AST_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !result[WE+WF]); // R8
endmodule

// File: tb/fp_exp_bench.sv
`timescale 1ns/1ps
module fp_exp_bench;
  localparam int WE = 6;
  localparam int WF = 10;
  localparam int W  = WE + WF + 1;
  localparam int BIAS = 31;

  logic clk = 1'b0;
  logic rst_n, in_valid, out_valid, ovf, unf;
  logic [W-1:0] x_in, result;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fp_exp #(.WE(WE), .WF(WF)) u_fp_exp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf));

  localparam logic [W-1:0] INF_V = {1'b0, 6'h3F, 10'h000};

  function automatic real p2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real fp2r(logic [W-1:0] v);
    real r;
    if (v[W-2:WF] == '0) return 0.0;
    r = (1.0 + real'(v[WF-1:0]) / 1024.0) * p2(int'(v[W-2:WF]) - BIAS);
    return v[W-1] ? -r : r;
  endfunction

  function automatic int lg2(real r);
    int e = 0;
    real m = r;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0)  begin m = m * 2.0; e--; end
    return e;
  endfunction

  function automatic logic [W-1:0] r2fp(real r);
    real mg = (r < 0.0) ? -r : r;
    int e = lg2(mg);
    int f = $rtoi((mg / p2(e) - 1.0) * 1024.0 + 0.5);
    if (f == 1024) begin f = 0; e++; end
    return {(r < 0.0), 6'(e + BIAS), 10'(f)};
  endfunction

  task automatic chk(bit ok, string req, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] v);
    real ev, got, ulp, diff, maxf, minn;
    x_in = v;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid, "R2", $sformatf("%0b", out_valid), "1");
    chk(!result[W-1], "R8", $sformatf("%h", result), "sign 0");
    maxf = (2.0 - p2(-WF)) * p2(BIAS);
    minn = p2(1 - BIAS);
    if (v[W-2:WF] == 6'h3F) begin
      if (v[WF-1:0] != '0)
        chk(result[W-2:WF] == 6'h3F && result[WF-1] && !ovf && !unf, "R7",
            $sformatf("%h", result), "NaN");
      else
        chk(result == (v[W-1] ? '0 : INF_V) && !ovf && !unf, "R7",
            $sformatf("%h f%0b%0b", result, ovf, unf), v[W-1] ? "0" : "inf");
    end else if (v[W-2:WF] == '0) begin
      chk(result == {1'b0, 6'(BIAS), 10'h0} && !ovf && !unf, "R4",
          $sformatf("%h", result), "1.0 exact");
    end else begin
      ev = $exp(fp2r(v));
      got = fp2r(result);
      if (ev > maxf * (1.0 + p2(-WF)))
        chk(ovf && result == INF_V, "R5", $sformatf("%h ovf=%0b", result, ovf), "inf ovf=1");
      else if (ev < minn * (1.0 - p2(-WF)))
        chk(unf && result == '0, "R6", $sformatf("%h unf=%0b", result, unf), "0 unf=1");
      else if (ovf)
        chk(ev > maxf * (1.0 - p2(-WF)) && result == INF_V, "R5",
            $sformatf("%h ovf", result), $sformatf("%g no ovf", ev));
      else if (unf)
        chk(ev < minn * (1.0 + p2(-WF)) && result == '0, "R6",
            $sformatf("%h unf", result), $sformatf("%g no unf", ev));
      else begin
        ulp = p2(lg2(ev) - WF);
        diff = got - ev;
        if (diff < 0.0) diff = -diff;
        chk(diff <= ulp, "R3", $sformatf("%g (x=%h)", got, v), $sformatf("%g", ev));
      end
    end
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    in_valid = 1'b0;
    x_in = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && result == '0 && !ovf && !unf, "R1",
        $sformatf("%0b %h %0b %0b", out_valid, result, ovf, unf), "all zero");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && result == '0 && !ovf && !unf, "R1",
        $sformatf("%0b %h %0b %0b", out_valid, result, ovf, unf), "all zero");

    run('0);
    run({1'b1, 16'h0000});
    run({1'b1, 6'h00, 10'h155});
    run({1'b0, 6'h3F, 10'h000});
    run({1'b1, 6'h3F, 10'h000});
    run({1'b0, 6'h3F, 10'h021});
    run({1'b0, 6'h3E, 10'h3FF});
    run({1'b1, 6'h3E, 10'h3FF});
    run(r2fp(1.0));
    run(r2fp(-1.0));
    run(r2fp(0.6931));
    run(r2fp(-0.6931));
    run(r2fp(21.0));
    run(r2fp(22.5));
    run(r2fp(-20.0));
    run(r2fp(-21.5));
    run(r2fp(1.0e-5));
    run(r2fp(-1.0e-5));
    begin
      logic [W-1:0] hi, lo;
      hi = r2fp($ln((2.0 - p2(-WF)) * p2(BIAS)));
      lo = r2fp($ln(p2(1 - BIAS)));
      for (int d = -4; d <= 4; d++) begin
        run(hi + W'(d));
        run(lo + W'(d));
      end
    end

    for (int i = 0; i < 3000; i++)
      run({1'($urandom % 2), 6'(17 + $urandom % 20), 10'($urandom)});
    for (int i = 0; i < 300; i++)
      run(W'($urandom));

    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R2", $sformatf("%0b", out_valid), "0 after idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule